// File: doc/BRIEF.md
# Fan Tachometer Period Measurement Unit

This block measures the pulse period on up to sixteen fan tachometer inputs, one channel at a time. Three clock-type settings are shared by all channels. Each setting holds an edge mode, a prescaler division and a measurement-unit word. Each channel has an enable bit and a 3-bit source field. The source field names one of eight PWM ports. Each port carries a 2-bit clock-type selector, and the channel uses the settings of that clock type.

Software arms a measurement by writing zero to the trigger register and then writing a one-hot channel bit. The unit waits for a qualifying edge and then counts divided clock ticks until the next qualifying edge. The result word then shows the count and sets its done flag. The count saturates: if no closing edge arrives before the counter is full, the result shows the all-ones count with the done flag set. Software converts the count to a fan speed.

The register interface is plain. A write takes effect at the clock edge where `wr_en` is high. A read is combinational from `rd_addr`. The block has no streaming data path, so no back-pressure applies.

Top module: `fan_tach_meas`

## Requirements
- R1: After reset every register reads zero, including the result word, whose done flag is clear.
- R2: A one-hot write to the trigger register (word 7) on a runnable channel starts a measurement. A channel is runnable when its enable bit is set, its clock type has index 0 to 2, and that type's enable bit is set. In rising mode, result word 8 then shows bit 31 set and bits 19:0 equal to floor(P / D), where P is the rising-to-rising interval in clocks and D is the prescale.
- R3: Edge mode 00 in type bits 5:4 measures from one falling edge to the next.
- R4: Edge mode 10 counts on both edges, so a square wave yields half its single-edge count.
- R5: The prescale D is 4 shifted left by twice the division field in type bits 3:1, giving 4, 16, 64 and so on.
- R6: A channel's source port is built from two registers. Its two low bits sit at bit 2×ch of word 4, and its high bit sits at bit 2×ch of word 5. The port's clock type sits at bit 2×port of word 6. Clock types 0, 1 and 2 use the type words at words 1, 2 and 3.
- R7: A channel whose enable bit (word 0, bit 16+ch) is clear does not start a measurement when triggered, and its done flag stays clear.
- R8: A trigger does not start a measurement if the selected type's enable bit (bit 0) is clear, or if the port selects clock type 3.
- R9: Any write to the trigger register clears the done flag and the count field on the next cycle.
- R10: If no closing qualifying edge arrives, including in reserved edge mode 11, the result shows the count maximum (all CNT_W bits set) with the done flag set.
- R11: A trigger value with more than one channel bit set starts nothing.
- R12: Configuration registers read back what was written, and reserved bits read zero. In a type word, bits 15:6 are reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | NCH | Raw tachometer pins, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address for writes |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register word address for reads |
| rd_data | output | 32 | Combinational read data |

## Verification
The assertions assume that software gives a trigger write exactly one cycle of `wr_en` and holds no other write over a running measurement. They also assume the tach pins may change at any time, since a two-stage synchroniser sits in front of the edge logic. The bench drives every write as a single-cycle strobe and reconfigures only between measurements. It generates the tach waveform as an exact square wave whose half period is a multiple of the prescale, so each expected count is an integer. It also shrinks the counter width so that the saturation cases finish in a few thousand cycles.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int REG_AW = 4;
  localparam int RES_DONE_BIT = 31;
  localparam int RES_CNT_BITS = 20;
  localparam int CH_EN_BASE = 16;
  localparam logic [31:0] TYPE_WR_MASK = 32'hFFFF_003F;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL      = 4'd0,
    A_TYPE0     = 4'd1,
    A_TYPE1     = 4'd2,
    A_TYPE2     = 4'd3,
    A_SRC_LO    = 4'd4,
    A_SRC_HI    = 4'd5,
    A_PORT_TYPE = 4'd6,
    A_TRIG      = 4'd7,
    A_RESULT    = 4'd8
  } reg_addr_e;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic [15:0] unit;
    logic [9:0]  rsvd;
    edge_mode_e  mode;
    logic [2:0]  div;
    logic        en;
  } type_word_t;
endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
  parameter int NCH    = 16,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tach_in,
  output logic [NCH-1:0] rise,
  output logic [NCH-1:0] fall
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [STAGES-1:0] sh;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[STAGES-2:0], tach_in[g]};
        prev <= sh[STAGES-1];
      end
    end
    assign rise[g] = sh[STAGES-1] & ~prev;
    assign fall[g] = ~sh[STAGES-1] & prev;
  end
endmodule

// File: rtl/tach_meas_engine.sv
module tach_meas_engine
  import tach_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             arm,
  input  edge_mode_e       mode,
  input  logic [2:0]       div,
  input  logic             rise_ev,
  input  logic             fall_ev,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  localparam int PRE_W = 17;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_e;
  st_e              st;
  edge_mode_e       mode_q;
  logic [2:0]       div_q;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] lim_m1;
  logic             ev;

  assign lim_m1 = (PRE_W'(4) << (2 * div_q)) - PRE_W'(1);

  always_comb begin
    unique case (mode_q)
      EDGE_FALL: ev = fall_ev;
      EDGE_RISE: ev = rise_ev;
      EDGE_BOTH: ev = rise_ev | fall_ev;
      default:   ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      count  <= '0;
      pre    <= '0;
      mode_q <= EDGE_FALL;
      div_q  <= '0;
    end else if (restart) begin
      st     <= arm ? S_WAIT : S_IDLE;
      done   <= 1'b0;
      count  <= '0;
      pre    <= '0;
      mode_q <= mode;
      div_q  <= div;
    end else if (st != S_IDLE) begin
      if (ev) begin
        if (st == S_WAIT) begin
          st    <= S_RUN;
          count <= '0;
          pre   <= PRE_W'(1);
        end else begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
      end else if (pre == lim_m1) begin
        pre   <= '0;
        count <= count + CNT_W'(1);
        if (count == CNT_MAX - CNT_W'(1)) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/fan_tach_meas.sv
module fan_tach_meas
  import tach_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int NPORT  = 8,
  parameter int NTYPES = 3,
  parameter int CNT_W  = 20,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    tach_in,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [31:0]       rd_data
);
  localparam int CH_W = $clog2(NCH);

  logic [NCH-1:0]     en_q;
  logic [2*NCH-1:0]   src_lo_q;
  logic [NCH-1:0]     src_hi_q;
  logic [2*NPORT-1:0] port_type_q;
  logic [NCH-1:0]     trig_q;
  logic [CH_W-1:0]    ch_q;
  type_word_t         type_q [NTYPES];

  logic               trig_wr;
  logic [CH_W-1:0]    sel_idx;
  logic [2:0]         src_sel;
  logic [1:0]         ptype;
  logic               sel_en;
  edge_mode_e         sel_mode;
  logic [2:0]         sel_div;
  logic               start;
  logic [NCH-1:0]     rise_v, fall_v;
  logic               busy, done;
  logic [CNT_W-1:0]   count;

  assign trig_wr = wr_en && (wr_addr == A_TRIG);

  always_comb begin
    sel_idx = '0;
    for (int c = 0; c < NCH; c++)
      if (wr_data[c]) sel_idx = CH_W'(c);
  end

  assign src_sel = {src_hi_q[sel_idx], src_lo_q[{sel_idx, 1'b0} +: 2]};
  assign ptype   = port_type_q[{src_sel, 1'b0} +: 2];

  always_comb begin
    sel_en   = 1'b0;
    sel_mode = EDGE_FALL;
    sel_div  = '0;
    for (int t = 0; t < NTYPES; t++) begin
      if (ptype == 2'(t)) begin
        sel_en   = type_q[t].en;
        sel_mode = type_q[t].mode;
        sel_div  = type_q[t].div;
      end
    end
  end

  assign start = trig_wr && $onehot(wr_data[NCH-1:0]) && en_q[sel_idx] && sel_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= '0;
      src_lo_q    <= '0;
      src_hi_q    <= '0;
      port_type_q <= '0;
      trig_q      <= '0;
      ch_q        <= '0;
      for (int t = 0; t < NTYPES; t++) type_q[t] <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTRL:      en_q        <= wr_data[CH_EN_BASE +: NCH];
        A_SRC_LO:    src_lo_q    <= wr_data[2*NCH-1:0];
        A_PORT_TYPE: port_type_q <= wr_data[2*NPORT-1:0];
        A_SRC_HI:
          for (int c = 0; c < NCH; c++) src_hi_q[c] <= wr_data[2*c];
        A_TRIG: begin
          trig_q <= wr_data[NCH-1:0];
          ch_q   <= sel_idx;
        end
        default:
          for (int t = 0; t < NTYPES; t++)
            if (wr_addr == A_TYPE0 + REG_AW'(t))
              type_q[t] <= type_word_t'(wr_data & TYPE_WR_MASK);
      endcase
    end
  end

  tach_edge_sync #(.NCH(NCH), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .rise(rise_v), .fall(fall_v)
  );

  tach_meas_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .restart(trig_wr), .arm(start),
    .mode(sel_mode), .div(sel_div),
    .rise_ev(rise_v[ch_q]), .fall_ev(fall_v[ch_q]),
    .busy(busy), .done(done), .count(count)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL:      rd_data[CH_EN_BASE +: NCH] = en_q;
      A_SRC_LO:    rd_data[2*NCH-1:0] = src_lo_q;
      A_PORT_TYPE: rd_data[2*NPORT-1:0] = port_type_q;
      A_SRC_HI:
        for (int c = 0; c < NCH; c++) rd_data[2*c] = src_hi_q[c];
      A_TRIG:      rd_data[NCH-1:0] = trig_q;
      A_RESULT: begin
        rd_data[RES_DONE_BIT] = done;
        rd_data[RES_CNT_BITS-1:0] = RES_CNT_BITS'(count);
      end
      default:
        for (int t = 0; t < NTYPES; t++)
          if (rd_addr == A_TYPE0 + REG_AW'(t)) rd_data = type_q[t];
    endcase
  end
endmodule

// File: rtl/tach_meas_chk.sv
module tach_meas_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_wr,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] count
);
  a_r9_trigger_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> !done);

  a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // Covers R7 and R11 as well: a trigger that cannot start leaves the unit idle.
  a_r8_no_start_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && !start) |=> !busy);

  a_r2_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !trig_wr) |=> (done && $stable(count)));

  a_r10_done_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind fan_tach_meas tach_meas_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .start(start),
  .busy(busy), .done(done), .count(count)
);

// File: tb/fan_tach_meas_bench.sv
module fan_tach_meas_bench;
  import tach_pkg::*;

  localparam int NCH = 16;
  localparam int CW  = 10;
  localparam logic [31:0] SAT = 32'h8000_0000 | ((32'd1 << CW) - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] tach_in = '0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit gen_on = 1'b0;
  int half = 40;
  int gcnt = 0;

  always #4 clk = ~clk;

  fan_tach_meas #(.CNT_W(CW)) u_fan_tach_meas (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (gen_on) begin
      if (gcnt >= half - 1) begin
        gcnt    <= 0;
        tach_in <= ~tach_in;
      end else gcnt <= gcnt + 1;
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output logic [31:0] r);
    r = '0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      rd(A_RESULT, r);
      if (r[31]) break;
    end
  endtask

  task automatic trigger(input logic [31:0] v);
    wr(A_TRIG, 32'd0);
    wr(A_TRIG, v);
  endtask

  typedef struct packed {
    logic [3:0]  ch;
    logic [2:0]  port;
    logic [1:0]  ptype;
    logic [1:0]  mode;
    logic [2:0]  div;
    logic [15:0] hp;
  } vec_t;

  // R2 rising, R3 falling, R4 both edges, R5 division 1, R6 split source field
  localparam vec_t VECS [5] = '{
    '{4'd0,  3'd0, 2'd0, 2'b01, 3'd0, 16'd40},
    '{4'd3,  3'd2, 2'd1, 2'b00, 3'd1, 16'd80},
    '{4'd5,  3'd6, 2'd2, 2'b10, 3'd0, 16'd60},
    '{4'd15, 3'd7, 2'd0, 2'b01, 3'd0, 16'd100},
    '{4'd9,  3'd1, 2'd1, 2'b10, 3'd1, 16'd96}
  };

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_RESULT, r);    chk("R1 result", r, 32'd0);
    rd(A_CTRL, r);      chk("R1 ctrl", r, 32'd0);
    rd(A_TYPE0, r);     chk("R1 type0", r, 32'd0);
    rd(A_PORT_TYPE, r); chk("R1 port type", r, 32'd0);

    // R12 readback with reserved bits zero
    wr(A_TYPE1, 32'hFFFF_FFFF);     rd(A_TYPE1, r);     chk("R12 type word", r, 32'hFFFF_003F);
    wr(A_CTRL, 32'hFFFF_FFFF);      rd(A_CTRL, r);      chk("R12 ctrl", r, 32'hFFFF_0000);
    wr(A_SRC_HI, 32'hFFFF_FFFF);    rd(A_SRC_HI, r);    chk("R12 src hi", r, 32'h5555_5555);
    wr(A_PORT_TYPE, 32'hFFFF_FFFF); rd(A_PORT_TYPE, r); chk("R12 port type", r, 32'h0000_FFFF);
    wr(A_TYPE1, 32'd0); wr(A_SRC_HI, 32'd0); wr(A_PORT_TYPE, 32'd0);

    gen_on = 1'b1;
    for (int v = 0; v < 5; v++) begin
      vec_t t;
      int dv, expc;
      t = VECS[v];
      half = int'(t.hp);
      dv = 4 << (2 * int'(t.div));
      expc = (t.mode == 2'b10) ? half / dv : (2 * half) / dv;
      wr(A_CTRL, 32'd1 << (16 + int'(t.ch)));
      wr(A_SRC_LO, 32'(t.port[1:0]) << (2 * int'(t.ch)));
      wr(A_SRC_HI, 32'(t.port[2]) << (2 * int'(t.ch)));
      wr(A_PORT_TYPE, 32'(t.ptype) << (2 * int'(t.port)));
      wr(4'(A_TYPE0 + t.ptype), {16'h00C0, 10'd0, t.mode, t.div, 1'b1});
      repeat (10) @(negedge clk);
      trigger(32'd1 << t.ch);
      wait_done(r);
      chk($sformatf("R2/R3/R4/R5/R6 vector %0d", v), r, 32'h8000_0000 | 32'(expc));
    end

    // R10 reserved edge mode saturates
    half = 40;
    wr(A_CTRL, 32'h0001_0000); wr(A_SRC_LO, 0); wr(A_SRC_HI, 0); wr(A_PORT_TYPE, 0);
    wr(A_TYPE0, {16'h00C0, 10'd0, 2'b11, 3'd0, 1'b1});
    trigger(32'd1);
    wait_done(r);
    chk("R10 reserved mode saturates", r, SAT);

    // R9 trigger write clears result
    wr(A_TRIG, 32'd0);
    rd(A_RESULT, r);
    chk("R9 trigger clears done and count", r, 32'd0);

    // R10 no edges at all
    gen_on = 1'b0;
    wr(A_TYPE0, {16'h00C0, 10'd0, 2'b01, 3'd0, 1'b1});
    trigger(32'd1);
    wait_done(r);
    chk("R10 no edges saturates", r, SAT);
    gen_on = 1'b1;

    // R7 disabled channel
    wr(A_CTRL, 32'd0);
    trigger(32'd1);
    repeat (400) @(negedge clk);
    rd(A_RESULT, r);
    chk("R7 disabled channel", r, 32'd0);

    // R8 type disabled
    wr(A_CTRL, 32'h0001_0000);
    wr(A_TYPE0, {16'h00C0, 10'd0, 2'b01, 3'd0, 1'b0});
    trigger(32'd1);
    repeat (400) @(negedge clk);
    rd(A_RESULT, r);
    chk("R8 type disabled", r, 32'd0);

    // R8 clock type 3
    wr(A_TYPE0, {16'h00C0, 10'd0, 2'b01, 3'd0, 1'b1});
    wr(A_PORT_TYPE, 32'h3);
    trigger(32'd1);
    repeat (400) @(negedge clk);
    rd(A_RESULT, r);
    chk("R8 clock type 3", r, 32'd0);

    // R11 two channel bits set
    wr(A_PORT_TYPE, 32'd0);
    wr(A_CTRL, 32'hFFFF_0000);
    trigger(32'h3);
    repeat (400) @(negedge clk);
    rd(A_RESULT, r);
    chk("R11 multi-bit trigger", r, 32'd0);

    // R2 sanity after the ignored cases: same setup measures again
    trigger(32'd1);
    wait_done(r);
    chk("R2 re-measure", r, 32'h8000_0000 | 32'd20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule